// File: doc/BRIEF.md
# Masked BCD Alarm Comparator

This block holds four alarm fields (day of month, hour, minute, second) and compares them with the current time, which arrives as packed BCD bytes. An outside timekeeping counter supplies the time and a once-per-second update strobe. The comparison is evaluated only on the cycle when that strobe is high. So each second that matches produces exactly one single-cycle event, and the same event sets a sticky flag.

Each alarm byte carries a mask bit in bit 7. A field whose mask is set drops out of the comparison. This gives repeating alarms: masking seconds alone fires every second of the matching minute. Masking everything except seconds fires once each minute, and masking all four fields fires on every strobe. The alarm bytes and a status byte are reached over a plain synchronous bus. Reads are combinational and writes take effect at the clock edge. Reading the status byte returns the flag and clears it.

Byte layout: bit 7 is the mask. The units digit sits in bits 3:0. The tens digit uses bits 6:4 for seconds and minutes, and bits 5:4 for hour and day, where bit 6 is unused. Bit positions that a field does not use are stored and read as 0. The same positions in the time inputs are not compared.

Top module: `alarm_cmp`

## Requirements
- R1: After reset, match_pulse and alarm_flag are 0 and all four alarm bytes read as 0x00.
- R2: Addresses 0, 1, 2 and 3 hold the seconds, minutes, hour and day alarm bytes. A write followed by a read returns the written byte with unused positions cleared: 0xFF reads back 0xFF at addresses 0 and 1, and 0xBF at addresses 2 and 3.
- R3: The comparison is made only on a cycle with tick high. Equal time values presented while tick is low produce no event.
- R4: match_pulse is high for exactly the one cycle following a tick cycle on which every unmasked field equals the time input.
- R5: A field with mask bit 7 set is ignored in the comparison, whatever its stored value.
- R6: When all four mask bits are set, every tick produces an event.
- R7: Any event sets alarm_flag, which then stays set until the status byte is read.
- R8: Reading address 4 returns alarm_flag in bit 0, with the other bits 0, and clears the flag on that edge. A set on the same edge wins over the clear.
- R9: A mismatch in any unmasked field suppresses the event and leaves alarm_flag unchanged.
- R10: Time input bits outside a field's used positions (bits 7 of seconds and minutes, bits 7:6 of hour and day) do not affect the comparison.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (clears the flag when it addresses status) |
| addr | input | AW | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational from addr |
| tick | input | 1 | Once-per-second time update strobe |
| now_sec | input | 8 | Current seconds, BCD |
| now_min | input | 8 | Current minutes, BCD |
| now_hour | input | 8 | Current hour, BCD |
| now_date | input | 8 | Current day of month, BCD |
| match_pulse | output | 1 | Single-cycle alarm event |
| alarm_flag | output | 1 | Sticky alarm flag |

## Verification
A stored alarm byte that is wrong, or a mask bit stuck, shows up at the ports within one cycle. It appears either on readback or as a missing or extra match_pulse on the cycle after the next tick. A flag register that holds the wrong state shows on alarm_flag the cycle after the event or the status read that should have changed it. It also shows on bit 0 of the next status read. The directed tests vary one field at a time so that each field's comparator and mask are exposed separately.

// File: rtl/alarm_cmp.sv
module alarm_cmp #(
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata,
  input  logic          tick,
  input  logic [7:0]    now_sec,
  input  logic [7:0]    now_min,
  input  logic [7:0]    now_hour,
  input  logic [7:0]    now_date,
  output logic          match_pulse,
  output logic          alarm_flag
);
  localparam logic [AW-1:0] A_SEC  = AW'(0);
  localparam logic [AW-1:0] A_MIN  = AW'(1);
  localparam logic [AW-1:0] A_HOUR = AW'(2);
  localparam logic [AW-1:0] A_DATE = AW'(3);
  localparam logic [AW-1:0] A_STAT = AW'(4);
  localparam logic [7:0] WIDE_MSK   = 8'hFF;
  localparam logic [7:0] NARROW_MSK = 8'hBF;

  logic [7:0] al_sec, al_min, al_hour, al_date;
  logic       hit, stat_rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      al_sec  <= '0;
      al_min  <= '0;
      al_hour <= '0;
      al_date <= '0;
    end else if (wr_en) begin
      case (addr)
        A_SEC:   al_sec  <= wdata & WIDE_MSK;
        A_MIN:   al_min  <= wdata & WIDE_MSK;
        A_HOUR:  al_hour <= wdata & NARROW_MSK;
        A_DATE:  al_date <= wdata & NARROW_MSK;
        default: ;
      endcase
    end
  end

  assign hit = (al_sec[7]  | (al_sec[6:0]  == now_sec[6:0]))  &
               (al_min[7]  | (al_min[6:0]  == now_min[6:0]))  &
               (al_hour[7] | (al_hour[5:0] == now_hour[5:0])) &
               (al_date[7] | (al_date[5:0] == now_date[5:0]));

  assign stat_rd = rd_en && (addr == A_STAT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      match_pulse <= 1'b0;
      alarm_flag  <= 1'b0;
    end else begin
      match_pulse <= tick & hit;
      if (tick & hit)   alarm_flag <= 1'b1;
      else if (stat_rd) alarm_flag <= 1'b0;
    end
  end

  always_comb begin
    case (addr)
      A_SEC:   rdata = al_sec;
      A_MIN:   rdata = al_min;
      A_HOUR:  rdata = al_hour;
      A_DATE:  rdata = al_date;
      A_STAT:  rdata = {7'b0, alarm_flag};
      default: rdata = 8'h00;
    endcase
  end
endmodule

module alarm_cmp_chk #(
  parameter int AW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rd_en,
  input logic [AW-1:0] addr,
  input logic          tick,
  input logic [7:0]    al_sec,
  input logic [7:0]    al_min,
  input logic [7:0]    al_hour,
  input logic [7:0]    al_date,
  input logic          match_pulse,
  input logic          alarm_flag
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk) !rst_n |=> (!match_pulse && !alarm_flag));
  // R3
  pulse_needs_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    match_pulse |-> $past(tick));
  // R7
  flag_follows_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    match_pulse |-> alarm_flag);
  // R8
  flag_clear_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(alarm_flag) |-> $past(rd_en && addr == AW'(4)));
  // R6
  all_masked_fires_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && al_sec[7] && al_min[7] && al_hour[7] && al_date[7]) |=> match_pulse);
  // R2
  unused_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (al_hour[6] == 1'b0) && (al_date[6] == 1'b0));
endmodule

bind alarm_cmp alarm_cmp_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .addr(addr), .tick(tick),
  .al_sec(al_sec), .al_min(al_min), .al_hour(al_hour), .al_date(al_date),
  .match_pulse(match_pulse), .alarm_flag(alarm_flag)
);

// File: tb/test_alarm_cmp.sv
module test_alarm_cmp;
  logic       clk = 0, rst_n = 0, wr_en = 0, rd_en = 0, tick = 0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0, rdata;
  logic [7:0] now_sec = '0, now_min = '0, now_hour = '0, now_date = '0;
  logic       match_pulse, alarm_flag;
  int errors = 0, checks = 0;

  always #4 clk = ~clk;

  alarm_cmp i_alarm_cmp (.*);

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd_chk(string req, logic [2:0] a, logic [7:0] exp);
    @(negedge clk); rd_en = 1; addr = a; #1;
    chk(req, rdata, exp);
    @(negedge clk); rd_en = 0;
  endtask

  task automatic set_time(logic [7:0] d, logic [7:0] h, logic [7:0] m, logic [7:0] s);
    now_date = d; now_hour = h; now_min = m; now_sec = s;
  endtask

  task automatic do_tick(string req, logic [7:0] d, logic [7:0] h, logic [7:0] m,
                         logic [7:0] s, logic exp);
    @(negedge clk); set_time(d, h, m, s); tick = 1;
    @(negedge clk); tick = 0;
    chk(req, {7'b0, match_pulse}, {7'b0, exp});
    @(negedge clk);
    chk({req, " single cycle (R4)"}, {7'b0, match_pulse}, 8'h00);
  endtask

  task automatic t_reset;
    chk("R1 pulse", {7'b0, match_pulse}, 8'h00);
    chk("R1 flag", {7'b0, alarm_flag}, 8'h00);
    for (int i = 0; i < 4; i++) rd_chk("R1 alarm byte", 3'(i), 8'h00);
  endtask

  task automatic t_regs;
    wr(0, 8'hFF); rd_chk("R2 sec", 0, 8'hFF);
    wr(1, 8'hFF); rd_chk("R2 min", 1, 8'hFF);
    wr(2, 8'hFF); rd_chk("R2 hour", 2, 8'hBF);
    wr(3, 8'hC5); rd_chk("R2 date", 3, 8'h85);
  endtask

  task automatic t_full_match;
    wr(3, 8'h15); wr(2, 8'h23); wr(1, 8'h59); wr(0, 8'h30);
    do_tick("R4 full match", 8'h15, 8'h23, 8'h59, 8'h30, 1);
    chk("R7 flag set", {7'b0, alarm_flag}, 8'h01);
    do_tick("R9 sec mismatch", 8'h15, 8'h23, 8'h59, 8'h31, 0);
    chk("R7 flag held", {7'b0, alarm_flag}, 8'h01);
    rd_chk("R8 status read", 4, 8'h01);
    chk("R8 flag cleared", {7'b0, alarm_flag}, 8'h00);
    rd_chk("R8 status after clear", 4, 8'h00);
  endtask

  task automatic t_no_tick;
    @(negedge clk); set_time(8'h15, 8'h23, 8'h59, 8'h30); tick = 0;
    repeat (3) @(negedge clk);
    chk("R3 no tick no pulse", {7'b0, match_pulse}, 8'h00);
    chk("R3 no tick no flag", {7'b0, alarm_flag}, 8'h00);
  endtask

  task automatic t_mismatch;
    do_tick("R9 date mismatch", 8'h16, 8'h23, 8'h59, 8'h30, 0);
    do_tick("R9 hour mismatch", 8'h15, 8'h22, 8'h59, 8'h30, 0);
    chk("R9 flag unchanged", {7'b0, alarm_flag}, 8'h00);
  endtask

  task automatic t_masks;
    wr(0, 8'h80);
    do_tick("R5 sec masked", 8'h15, 8'h23, 8'h59, 8'h07, 1);
    do_tick("R5 min unmasked still compared", 8'h15, 8'h23, 8'h58, 8'h07, 0);
    wr(1, 8'h80); wr(2, 8'hA0);
    do_tick("R5 hour masked", 8'h15, 8'h04, 8'h12, 8'h44, 1);
    wr(3, 8'h80);
    do_tick("R6 all masked a", 8'h01, 8'h00, 8'h00, 8'h00, 1);
    do_tick("R6 all masked b", 8'h31, 8'h11, 8'h37, 8'h59, 1);
    rd_chk("R8 clear", 4, 8'h01);
  endtask

  task automatic t_unused;
    wr(3, 8'h28); wr(2, 8'h12); wr(1, 8'h45); wr(0, 8'h09);
    do_tick("R10 high bits ignored", 8'hE8, 8'hD2, 8'hC5, 8'h89, 1);
    rd_chk("R8 clear", 4, 8'h01);
  endtask

  task automatic t_set_wins;
    @(negedge clk); set_time(8'h28, 8'h12, 8'h45, 8'h09); tick = 1; rd_en = 1; addr = 4;
    @(negedge clk); tick = 0; rd_en = 0;
    chk("R8 set wins over clear", {7'b0, alarm_flag}, 8'h01);
    rd_chk("R8 clear after", 4, 8'h01);
    chk("R8 flag cleared", {7'b0, alarm_flag}, 8'h00);
  endtask

  initial begin
    #1;
    t_reset;
    @(negedge clk); rst_n = 1;
    t_regs;
    t_full_match;
    t_no_tick;
    t_mismatch;
    t_masks;
    t_unused;
    t_set_wins;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #200000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule